// File: doc/BRIEF.md
# Hot-Plug Detect Sink Status Controller

This block drives the hot-plug detect line of a bridge that converts a packetized display link into analog video. It watches a power-on-initialization-done input, a downstream monitor-present signal and a mode strap. From these it produces the HPD level, a one-bit sink-count register value, a sticky "downstream port status changed" bit that software clears, and a hold signal. The hold keeps the sync outputs low and blanks the colour outputs of the video path.

Two hot-plug policies are chosen by the strap, which is latched on the first clock after reset. With the strap low, HPD rises after initialization whether or not a monitor is attached. Later attach or detach events are reported with a short low pulse on HPD, which acts as an interrupt, together with the sticky bit. With the strap high, HPD simply mirrors the debounced presence of a downstream monitor. The presence input goes through a synchronizer and a cycle-count debouncer before any decision uses it.

Top module: `hpd_sink_ctrl`

## Requirements
- R1: After reset, hpd_o=0, sink_count_o=0, port_chg_o=0 and video_hold_o=1. HPD stays low for as long as init_done_i has not been seen high.
- R2: Strap low: the clock edge that first sees init_done_i high loads sink_count_o with the debounced presence (1 present, 0 absent). hpd_o goes high on the following edge, whether sink_count_o is 0 or 1.
- R3: Strap low, after HPD is up: each debounced presence change updates sink_count_o, sets port_chg_o to 1, and drives hpd_o low for exactly IRQ_CYC cycles. All three happen on the same edge.
- R4: Strap low: a change that arrives while a pulse is low is held pending. Once the current pulse ends, hpd_o stays high for IRQ_CYC cycles and then the pending pulse of IRQ_CYC cycles is issued.
- R5: port_chg_o stays 1 until port_chg_clr_i is 1 at a clock edge. If a new change and the clear fall on the same edge, the bit stays 1.
- R6: Strap high: hpd_o stays low after initialization until a monitor is present, then follows the debounced presence. sink_count_o follows the presence on the same edge.
- R7: A change on mon_present_i becomes the debounced level DEB_CYC+2 edges after it is applied and acts on the outputs one edge later. A pulse on the input shorter than DEB_CYC cycles is ignored.
- R8: mode_strap_i is sampled on the first clock edge after reset release. Later changes to it have no effect until the next reset.
- R9: video_hold_o is 1 during initialization and whenever HPD is low at its level or link_ok_i is 0. It goes to 0 one edge after link_ok_i is seen with HPD up.
- R10: Strap high: port_chg_o never sets and no interrupt pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Power-on initialization complete |
| mon_present_i | input | 1 | Raw downstream monitor-present level (asynchronous) |
| mode_strap_i | input | 1 | Hot-plug policy strap: 0 interrupt mode, 1 follow-presence mode |
| link_ok_i | input | 1 | Upstream link established |
| port_chg_clr_i | input | 1 | Clear strobe for the sticky status-changed bit |
| hpd_o | output | 1 | Hot-plug detect line to the upstream source |
| sink_count_o | output | 1 | Sink-count register value (1 present, 0 absent) |
| port_chg_o | output | 1 | Sticky downstream-port-status-changed bit |
| video_hold_o | output | 1 | Blank colour outputs and hold sync low |

## Verification
The tests drive all inputs on the falling clock edge and count the rising edges after that, sampling on later falling edges.

- Loading the sink count: due one edge after init_done_i is applied, with HPD rising one edge later.
- Presence changes: the debounced level flips at edge DEB_CYC+2 after the input changes, so sink count, sticky bit and interrupt start or HPD level are checked at edge DEB_CYC+3. The edge before is also sampled to show that nothing has moved early.
- Interrupt pulses: checked on their last low cycle and on their first high cycle, to pin their length.
- Hold: checked one edge after link_ok_i or HPD changes.

// File: rtl/hpd_ctrl_pkg.sv
package hpd_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_LOAD = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_LOW  = 2'd1,
        IRQ_GAP  = 2'd2
    } irq_e;

    typedef struct packed {
        phase_e phase;
        logic   strap_ok;
        logic   strap_hi;
        logic   hpd;
        logic   sink;
        logic   chg;
        logic   hold;
    } ctrl_t;

endpackage

// File: rtl/hpd_presence_filter.sv
module hpd_presence_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int DCW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic           level;
        logic [DCW-1:0] cnt;
    } deb_t;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_last;
    deb_t                   deb_d, deb_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= raw_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign sync_last = sync_q[SYNC_STAGES-1];

    always_comb begin
        deb_d = deb_q;
        if (sync_last == deb_q.level) begin
            deb_d.cnt = '0;
        end else if (deb_q.cnt == DCW'(DEB_CYC - 1)) begin
            deb_d.level = sync_last;
            deb_d.cnt   = '0;
        end else begin
            deb_d.cnt = deb_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) deb_q <= '0;
        else        deb_q <= deb_d;
    end

    assign level_o = deb_q.level;

    // R7
    level_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_q.level != $past(deb_q.level)) |-> ($past(sync_last) == deb_q.level));

    // R7
    deb_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deb_q.cnt < DCW'(DEB_CYC));

endmodule

// File: rtl/hpd_irq_pulse.sv
module hpd_irq_pulse
    import hpd_ctrl_pkg::*;
#(
    parameter int IRQ_CYC = 37500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic low_o
);
    localparam int ICW = $clog2(IRQ_CYC + 1);

    typedef struct packed {
        irq_e           st;
        logic           pend;
        logic [ICW-1:0] cnt;
    } irq_t;

    irq_t irq_d, irq_q;
    logic at_end;

    assign at_end = (irq_q.cnt == ICW'(IRQ_CYC - 1));

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q.st)
            IRQ_IDLE: begin
                if (req_i) begin
                    irq_d.st  = IRQ_LOW;
                    irq_d.cnt = '0;
                end
            end
            IRQ_LOW: begin
                if (req_i) irq_d.pend = 1'b1;
                if (at_end) begin
                    irq_d.st  = IRQ_GAP;
                    irq_d.cnt = '0;
                end else begin
                    irq_d.cnt = irq_q.cnt + 1'b1;
                end
            end
            IRQ_GAP: begin
                if (req_i) irq_d.pend = 1'b1;
                if (at_end) begin
                    irq_d.cnt = '0;
                    if (irq_q.pend || req_i) begin
                        irq_d.st   = IRQ_LOW;
                        irq_d.pend = 1'b0;
                    end else begin
                        irq_d.st = IRQ_IDLE;
                    end
                end else begin
                    irq_d.cnt = irq_q.cnt + 1'b1;
                end
            end
            default: irq_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign low_o = (irq_q.st == IRQ_LOW);

    // R3
    irq_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_o) |-> ($past(req_i) || $past(irq_q.pend)));

    // R4
    irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_o) |=> !low_o);

    // R3
    irq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q.cnt < ICW'(IRQ_CYC));

endmodule

// File: rtl/hpd_sink_ctrl.sv
module hpd_sink_ctrl
    import hpd_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 1000,
    parameter int IRQ_CYC     = 37500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done_i,
    input  logic mon_present_i,
    input  logic mode_strap_i,
    input  logic link_ok_i,
    input  logic port_chg_clr_i,
    output logic hpd_o,
    output logic sink_count_o,
    output logic port_chg_o,
    output logic video_hold_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  det_lvl;
    logic  irq_req;
    logic  irq_low;

    hpd_presence_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_CYC    (DEB_CYC)
    ) i_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (mon_present_i),
        .level_o(det_lvl)
    );

    hpd_irq_pulse #(
        .IRQ_CYC(IRQ_CYC)
    ) i_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .req_i(irq_req),
        .low_o(irq_low)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        irq_req = 1'b0;

        if (!ctrl_q.strap_ok) begin
            ctrl_d.strap_ok = 1'b1;
            ctrl_d.strap_hi = mode_strap_i;
        end

        unique case (ctrl_q.phase)
            PH_INIT: begin
                if (ctrl_q.strap_ok && init_done_i) begin
                    ctrl_d.phase = PH_LOAD;
                    ctrl_d.sink  = det_lvl;
                end
            end
            PH_LOAD: begin
                ctrl_d.phase = PH_RUN;
                ctrl_d.hpd   = ctrl_q.strap_hi ? det_lvl : 1'b1;
            end
            PH_RUN: begin
                if (ctrl_q.strap_hi) begin
                    ctrl_d.hpd  = det_lvl;
                    ctrl_d.sink = det_lvl;
                end else if (det_lvl != ctrl_q.sink) begin
                    ctrl_d.sink = det_lvl;
                    irq_req     = 1'b1;
                end
            end
            default: ctrl_d.phase = PH_INIT;
        endcase

        if (irq_req)             ctrl_d.chg = 1'b1;
        else if (port_chg_clr_i) ctrl_d.chg = 1'b0;

        ctrl_d.hold = !((ctrl_q.phase == PH_RUN) && ctrl_q.hpd && link_ok_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.phase <= PH_INIT;
            ctrl_q.hold  <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign hpd_o        = ctrl_q.hpd && !irq_low;
    assign sink_count_o = ctrl_q.sink;
    assign port_chg_o   = ctrl_q.chg;
    assign video_hold_o = ctrl_q.hold;

    // R1
    hpd_init_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase != PH_RUN) |-> !hpd_o);

    // R5
    chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_chg_o && !port_chg_clr_i) |=> port_chg_o);

    // R6
    follow_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_RUN && ctrl_q.strap_hi) |=> (hpd_o == $past(det_lvl)));

    // R8
    strap_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.strap_ok && $past(ctrl_q.strap_ok)) |-> $stable(ctrl_q.strap_hi));

    // R9
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !video_hold_o |-> ($past(link_ok_i) && ctrl_q.phase == PH_RUN));

    // R10
    no_irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.strap_ok && ctrl_q.strap_hi) |-> (!irq_low && !irq_req));

endmodule

// File: tb/test_hpd_sink_ctrl.sv
module test_hpd_sink_ctrl;
    localparam int D = 6;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done = 1'b0;
    logic mon = 1'b0;
    logic strap = 1'b0;
    logic link_ok = 1'b0;
    logic clr = 1'b0;
    logic hpd, sink, chg, hold;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hpd_sink_ctrl #(.SYNC_STAGES(2), .DEB_CYC(D), .IRQ_CYC(Q)) i_hpd_sink_ctrl (
        .clk(clk), .rst_n(rst_n), .init_done_i(init_done), .mon_present_i(mon),
        .mode_strap_i(strap), .link_ok_i(link_ok), .port_chg_clr_i(clr),
        .hpd_o(hpd), .sink_count_o(sink), .port_chg_o(chg), .video_hold_o(hold)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic s, input logic m);
        @(negedge clk);
        rst_n = 1'b0; strap = s; mon = m; init_done = 1'b0; link_ok = 1'b0; clr = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic bring_up();
        cyc(D + 6);
        init_done = 1'b1;
        cyc(2);
    endtask

    task automatic t_reset_and_init();
        do_reset(1'b0, 1'b1);
        chk("R1", "hpd after reset", hpd, 1'b0);
        chk("R1", "sink after reset", sink, 1'b0);
        chk("R1", "chg after reset", chg, 1'b0);
        chk("R1", "hold after reset", hold, 1'b1);
        cyc(30);
        chk("R1", "hpd while init pending", hpd, 1'b0);
        init_done = 1'b1;
        cyc(1);
        chk("R2", "sink loaded on init", sink, 1'b1);
        chk("R2", "hpd not yet high", hpd, 1'b0);
        cyc(1);
        chk("R2", "hpd high after load", hpd, 1'b1);
        chk("R9", "hold before link", hold, 1'b1);
        link_ok = 1'b1;
        cyc(1);
        chk("R9", "hold released", hold, 1'b0);
        link_ok = 1'b0;
        cyc(1);
        chk("R9", "hold back on link loss", hold, 1'b1);
    endtask

    task automatic t_change_and_sticky();
        do_reset(1'b0, 1'b0);
        bring_up();
        chk("R2", "hpd high with no monitor", hpd, 1'b1);
        chk("R2", "sink zero", sink, 1'b0);
        mon = 1'b1;
        cyc(D + 2);
        chk("R7", "sink not yet updated", sink, 1'b0);
        chk("R7", "hpd not yet pulsed", hpd, 1'b1);
        cyc(1);
        chk("R3", "sink updated", sink, 1'b1);
        chk("R3", "chg set", chg, 1'b1);
        chk("R3", "pulse starts", hpd, 1'b0);
        cyc(Q - 1);
        chk("R3", "pulse last low cycle", hpd, 1'b0);
        cyc(1);
        chk("R3", "pulse ended", hpd, 1'b1);
        cyc(5);
        chk("R5", "chg still set", chg, 1'b1);
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
        chk("R5", "chg cleared", chg, 1'b0);
        cyc(Q);
        mon = 1'b0;
        cyc(D + 2);
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
        chk("R5", "set wins over clear", chg, 1'b1);
        chk("R3", "sink back to zero", sink, 1'b0);
        cyc(2 * Q + 4);
    endtask

    task automatic t_queue();
        do_reset(1'b0, 1'b0);
        bring_up();
        mon = 1'b1;
        cyc(D + 3);
        chk("R4", "first pulse low", hpd, 1'b0);
        cyc(2);
        mon = 1'b0;
        cyc(Q - 2);
        chk("R4", "high after first pulse", hpd, 1'b1);
        chk("R4", "sink follows second change", sink, 1'b0);
        cyc(Q - 1);
        chk("R4", "gap last cycle", hpd, 1'b1);
        cyc(1);
        chk("R4", "queued pulse starts", hpd, 1'b0);
        cyc(Q - 1);
        chk("R4", "queued pulse last low", hpd, 1'b0);
        cyc(1);
        chk("R4", "queued pulse ended", hpd, 1'b1);
    endtask

    task automatic t_high_mode();
        do_reset(1'b1, 1'b0);
        bring_up();
        chk("R6", "hpd low without monitor", hpd, 1'b0);
        link_ok = 1'b1;
        cyc(3);
        chk("R9", "hold kept while hpd low", hold, 1'b1);
        mon = 1'b1;
        cyc(D - 1);
        mon = 1'b0;
        cyc(D + 5);
        chk("R7", "glitch ignored hpd", hpd, 1'b0);
        chk("R7", "glitch ignored sink", sink, 1'b0);
        mon = 1'b1;
        cyc(D + 2);
        chk("R6", "hpd not yet high", hpd, 1'b0);
        cyc(1);
        chk("R6", "hpd follows attach", hpd, 1'b1);
        chk("R6", "sink follows attach", sink, 1'b1);
        chk("R10", "no chg on attach", chg, 1'b0);
        cyc(1);
        chk("R9", "hold released", hold, 1'b0);
        cyc(Q);
        chk("R10", "no pulse in follow mode", hpd, 1'b1);
        mon = 1'b0;
        cyc(D + 3);
        chk("R6", "hpd follows detach", hpd, 1'b0);
        chk("R6", "sink follows detach", sink, 1'b0);
        chk("R10", "no chg on detach", chg, 1'b0);
        cyc(1);
        chk("R9", "hold back on detach", hold, 1'b1);
    endtask

    task automatic t_strap_latch();
        do_reset(1'b0, 1'b0);
        strap = 1'b1;
        bring_up();
        chk("R8", "late strap high ignored", hpd, 1'b1);
        do_reset(1'b1, 1'b0);
        strap = 1'b0;
        bring_up();
        chk("R8", "late strap low ignored", hpd, 1'b0);
    endtask

    initial begin
        t_reset_and_init();
        t_change_and_sticky();
        t_queue();
        t_high_mode();
        t_strap_latch();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule